// File: doc/BRIEF.md
# Flash Erase Unlock Sequencer

This block guards the erase command of an on-chip flash array. Software reaches it through a small register write bus: an address, a data byte and a write strobe. An erase starts only when a valid arming write is followed by the matching command key written to the command register. Any other order or value ends the attempt and starts nothing.

There are two erase paths. A whole-array erase is armed by setting bit 1 of the control register. It is then confirmed with the key 0xAA, and it is accepted only while the debug port is enabled. A single-page erase is armed by writing the page number into bits [7:1] of the page register. It is then confirmed with the key 0x55.

When an erase is accepted, the block gives a one-cycle start pulse together with the erase type and the page number. It then holds a busy flag for a set number of cycles. While busy is high, the command register is closed to new commands.

Top module: `flash_erase_unlock`

## Requirements
- R1: After reset, `busy` and `erase_start` are low.
- R2: A control write with data bit 1 set, followed by a command write of 0xAA while `dbg_en` is high, makes `erase_start` high for exactly one cycle, in the cycle after the command write, with `erase_mass` = 1.
- R3: A whole-array attempt confirmed while `dbg_en` is low starts no erase and uses up the arming.
- R4: A page register write with the page number in data bits [7:1], followed by a command write of 0x55, pulses `erase_start` with `erase_mass` = 0 and `erase_page` equal to that number. This covers pages 0 to 63.
- R5: A page number of 64 or above (data bit 7 set) is rejected at the command write, and no erase starts.
- R6: A command write of any value other than the key of the armed path, or a command write with nothing armed, starts no erase. It clears all arming.
- R7: Every accepted or rejected command clears both arms. A repeated key without a new arming write starts nothing. A control write with bit 1 clear also disarms the whole-array path.
- R8: `busy` rises together with `erase_start` and stays high for exactly ERASE_CYCLES cycles.
- R9: Command writes while `busy` is high, including in its last cycle, have no effect. Arming that is already held survives them.
- R10: A key that belongs to the other path (0xAA with only a page armed, 0x55 with only the whole-array path armed) starts no erase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register address (control 0x10, page 0x11, command 0x12) |
| wr_data | input | 8 | Write data |
| dbg_en | input | 1 | Debug port enabled; required for whole-array erase |
| erase_start | output | 1 | One-cycle pulse when an erase begins |
| erase_mass | output | 1 | 1 = whole-array erase, 0 = page erase |
| erase_page | output | 6 | Page number of the last page erase |
| busy | output | 1 | Erase in progress |

## Verification
Two events can fall on the same clock edge: the end of the busy window and a new command write. The bench times a valid, fully armed command write so that it is sampled at the edge where the erase counter expires. It then checks that no start pulse follows and that busy falls normally. A second case sends a command during the busy window and checks that the arming it found is still held. This is shown by a later command that succeeds without a new arming write.

// File: rtl/flash_erase_unlock.sv
module flash_erase_unlock #(
  parameter int          ARRAY_BYTES  = 32768,
  parameter int          PAGE_BYTES   = 512,
  parameter int          ERASE_CYCLES = 1000,
  parameter logic [7:0]  ADR_CTRL     = 8'h10,
  parameter logic [7:0]  ADR_PAGE     = 8'h11,
  parameter logic [7:0]  ADR_CMD      = 8'h12,
  parameter logic [7:0]  KEY_MASS     = 8'hAA,
  parameter logic [7:0]  KEY_PAGE     = 8'h55
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic       dbg_en,
  output logic       erase_start,
  output logic       erase_mass,
  output logic [5:0] erase_page,
  output logic       busy
);
  localparam int PAGES = ARRAY_BYTES / PAGE_BYTES;
  localparam int PW    = $clog2(PAGES);
  localparam int CW    = $clog2(ERASE_CYCLES + 1);

  logic          mass_arm, page_arm;
  logic [6:0]    page_q;
  logic [CW-1:0] cnt;

  wire cmd_hit  = wr_en && wr_addr == ADR_CMD && !busy;
  wire go_mass  = cmd_hit && wr_data == KEY_MASS && mass_arm && dbg_en;
  wire go_page  = cmd_hit && wr_data == KEY_PAGE && page_arm && (int'(page_q) < PAGES);
  wire go       = go_mass || go_page;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mass_arm <= 1'b0;
      page_arm <= 1'b0;
      page_q   <= '0;
    end else if (cmd_hit) begin
      mass_arm <= 1'b0;
      page_arm <= 1'b0;
    end else if (wr_en && wr_addr == ADR_CTRL) begin
      mass_arm <= wr_data[1];
    end else if (wr_en && wr_addr == ADR_PAGE) begin
      page_arm <= 1'b1;
      page_q   <= wr_data[7:1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      erase_start <= 1'b0;
      erase_mass  <= 1'b0;
      erase_page  <= '0;
      busy        <= 1'b0;
      cnt         <= '0;
    end else begin
      erase_start <= go;
      if (go) begin
        erase_mass <= go_mass;
        if (go_page) erase_page <= 6'(page_q[PW-1:0]);
        busy <= 1'b1;
        cnt  <= CW'(ERASE_CYCLES - 1);
      end else if (busy) begin
        if (cnt == '0) busy <= 1'b0;
        else           cnt  <= cnt - 1'b1;
      end
    end
  end

  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |=> !erase_start);                                          // R2
  AST_MASS_NEEDS_DBG: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_start && erase_mass) |-> $past(dbg_en));                          // R3
  AST_START_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |-> busy);                                                   // R8
  AST_NO_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_start && $past(rst_n)) |-> !$past(busy));                         // R9
  AST_START_NEEDS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |-> ($past(wr_en) && $past(wr_addr) == ADR_CMD));            // R6
  AST_TYPE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !erase_start) |-> $stable(erase_mass));                          // R8
endmodule

// File: tb/flash_erase_unlock_test.sv
module flash_erase_unlock_test;
  localparam int E = 8;
  localparam logic [7:0] AC = 8'h10, AP = 8'h11, AX = 8'h12;

  logic clk = 0, rst_n = 0, wr_en = 0, dbg_en = 1;
  logic [7:0] wr_addr = 0, wr_data = 0;
  logic erase_start, erase_mass, busy;
  logic [5:0] erase_page;
  int runs = 0, fails = 0;

  always #2 clk = ~clk;

  flash_erase_unlock #(.ERASE_CYCLES(E)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .dbg_en(dbg_en), .erase_start(erase_start), .erase_mass(erase_mass),
    .erase_page(erase_page), .busy(busy));

  function automatic logic [31:0] v(logic [7:0] a, logic [7:0] d, logic dbg,
                                     logic s, logic m, logic [5:0] p, logic [3:0] r);
    return {a, d, dbg, s, m, p, 3'b0, r};
  endfunction

  localparam int N = 26;
  localparam logic [31:0] VEC [N] = '{
    v(AC, 8'h02, 1, 0, 0, 0, 2),
    v(AX, 8'hAA, 1, 1, 1, 0, 2),    // R2 whole-array
    v(AX, 8'hAA, 1, 0, 0, 0, 7),    // R7 no re-arm
    v(AP, 8'h06, 1, 0, 0, 0, 4),
    v(AX, 8'h55, 1, 1, 0, 3, 4),    // R4 page 3
    v(AP, 8'h7E, 1, 0, 0, 0, 4),
    v(AX, 8'h55, 1, 1, 0, 63, 4),   // R4 page 63
    v(AP, 8'h80, 1, 0, 0, 0, 5),
    v(AX, 8'h55, 1, 0, 0, 0, 5),    // R5 page 64
    v(AP, 8'h0A, 1, 0, 0, 0, 6),
    v(AX, 8'h33, 1, 0, 0, 0, 6),    // R6 wrong key
    v(AX, 8'h55, 1, 0, 0, 0, 6),    // R6 arm cleared
    v(AC, 8'h02, 0, 0, 0, 0, 3),
    v(AX, 8'hAA, 0, 0, 0, 0, 3),    // R3 no debug
    v(AX, 8'hAA, 1, 0, 0, 0, 3),    // R3 arming used up
    v(AP, 8'h04, 1, 0, 0, 0, 10),
    v(AX, 8'hAA, 1, 0, 0, 0, 10),   // R10 mass key, page armed
    v(AC, 8'h02, 1, 0, 0, 0, 10),
    v(AX, 8'h55, 1, 0, 0, 0, 10),   // R10 page key, mass armed
    v(AC, 8'h02, 1, 0, 0, 0, 7),
    v(AC, 8'h00, 1, 0, 0, 0, 7),
    v(AX, 8'hAA, 1, 0, 0, 0, 7),    // R7 disarmed by bit 1 clear
    v(AC, 8'h02, 1, 0, 0, 0, 7),
    v(AP, 8'h00, 1, 0, 0, 0, 7),
    v(AX, 8'h55, 1, 1, 0, 0, 7),    // R7 page 0 start
    v(AX, 8'hAA, 1, 0, 0, 0, 7)     // R7 mass arm cleared by command
  };

  task automatic chk(bit ok, int r, string what, int act, int exp);
    runs++;
    if (!ok) begin
      fails++;
      $display("FAIL R%0d %s: actual %0d expected %0d", r, what, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk(busy == 0 && erase_start == 0, 1, "reset outputs", {busy, erase_start}, 0); // R1
    rst_n = 1;
    @(negedge clk);

    foreach (VEC[i]) begin
      logic [31:0] e = VEC[i];
      dbg_en = e[15];
      wr(e[31:24], e[23:16]);
      chk(erase_start == e[14], int'(e[3:0]), $sformatf("vec %0d start", i), erase_start, e[14]);
      if (e[14]) begin
        chk(erase_mass == e[13], int'(e[3:0]), $sformatf("vec %0d type", i), erase_mass, e[13]);
        if (!e[13])
          chk(erase_page == e[12:7], int'(e[3:0]), $sformatf("vec %0d page", i), erase_page, e[12:7]);
        @(negedge clk);
        chk(erase_start == 0, 2, "pulse width", erase_start, 0);  // R2
        wait_idle();
      end
    end

    // R8: busy length
    dbg_en = 1;
    wr(AP, 8'h02);
    wr(AX, 8'h55);
    n = 0;
    while (busy && n < 100) begin n++; @(negedge clk); end
    chk(n == E, 8, "busy cycles", n, E);

    // R9: command mid-busy ignored, held arming survives
    wr(AP, 8'h0C);
    wr(AX, 8'h55);
    chk(erase_start == 1 && erase_page == 6, 4, "page 6 start", erase_page, 6);
    wr(AP, 8'h0A);
    wr(AX, 8'h55);
    chk(erase_start == 0, 9, "cmd during busy", erase_start, 0);
    wait_idle();
    wr(AX, 8'h55);
    chk(erase_start == 1 && erase_page == 5, 9, "arm kept after busy", erase_page, 5);

    // R9: command in the last busy cycle, same edge busy ends
    wr(AP, 8'h0E);
    repeat (E - 2) @(negedge clk);
    chk(busy == 1, 9, "still busy before last edge", busy, 1);
    wr(AX, 8'h55);
    chk(erase_start == 0 && busy == 0, 9, "last-cycle cmd ignored", {erase_start, busy}, 0);
    wr(AX, 8'h55);
    chk(erase_start == 1 && erase_page == 7, 9, "arm kept after last-cycle cmd", erase_page, 7);
    wait_idle();

    // R1: reset mid-busy
    wr(AC, 8'h02);
    wr(AX, 8'hAA);
    rst_n = 0;
    @(negedge clk);
    chk(busy == 0 && erase_start == 0, 1, "reset clears busy", busy, 0);
    rst_n = 1;
    wr(AX, 8'hAA);
    chk(erase_start == 0, 1, "reset clears arming", erase_start, 0);

    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule